// File: doc/BRIEF.md
# Machine State Register Write Controller

This block owns a processor's machine state register and turns every software write of it into a committed value plus the side effects that the write implies. A write is first cut down to the bits the implementation lets software change, then the hypervisor bit is guarded, and on a 64-bit server configuration the privilege-drop rule forces interrupts and both translations on. Alongside the stored value the block raises one-cycle requests: a translation flush when the address translation context changes, a shadow-register exchange when the temporary register bank bit flips, and a halt request when a power-save write meets an idle interrupt state and a positive power check. It also keeps the exception vector prefix and derives, without delay from the stored value, the instruction-side and data-side MMU mode indices and a hidden-flags vector for the decode logic.

A small two-state machine sequences the request outputs. In state ST_IDLE all requests are low; a write strobe takes the transition LOAD to ST_PULSE, where the requests captured with the write are presented for exactly one cycle. From ST_PULSE a further write takes REPEAT (stay in ST_PULSE with freshly captured requests), and a cycle without a write takes RETIRE back to ST_IDLE. Bit positions are parameters; the reset value of the register is a parameter whose default has only the hypervisor bit set. With default parameters the positions are: LE 0, SA 1, IS 2, DS 3, DR 4, IR 5, EP 6, AP 7, BE 9, SE 10, FP 13, PR 14, EE 15, TGPR 17, POW 18, VSX 23, VR 25, GS 28, CM 31, HV 60, SF 63, in a 64-bit register.

Top module: `msr_write_ctrl`

## Requirements
- R1: While reset is held and after its release with no write, the register equals its reset value (bit 60 only with defaults), the exception prefix is 0 and flush, swap and halt outputs are 0.
- R2: On a write, every stored bit other than HV, EE, IR and DR equals the written bit ANDed with the corresponding writable-mask bit (positions as listed above).
- R3: The HV bit (60) keeps its previous value unless the hv-permission input is 1 and the current HV bit is 1, in which case it takes the masked written value; so HV can be cleared but never set by a write.
- R4: The flush output pulses in the cycle after a write whose masked value differs from the current register in IR (5) or DR (4), or, when the embedded strap is 1, in GS (28).
- R5: The swap output pulses in the cycle after a write when the temporary-register strap is 1 and the masked TGPR bit (17) differs from the current one.
- R6: When the masked EP bit (6) differs from the current one, the exception prefix becomes 0xFFF00000 if the new EP is 1 and 0 if it is 0; otherwise it holds.
- R7: With the 64-bit server strap at 1, a write whose masked PR bit (14) is 1 stores EE (15), IR (5) and DR (4) as 1.
- R8: With the embedded strap at 0, each mode index is {HV, NOT IR, NOT PR} for the instruction side and {HV, NOT DR, NOT PR} for the data side (bit 2 down to bit 0), from the stored register.
- R9: With the embedded strap at 1, the instruction index is {GS, IS, NOT PR} and the data index is {GS, DS, NOT PR}.
- R10: The hidden-flags output equals the stored register ANDed with the bits VR, AP, SA, PR, FP, SE, BE, LE, VSX, IR, DR, CM, SF and HV, ORed with the external flags input.
- R11: The halt output pulses in the cycle after a write whose masked POW bit (18) is 1 while the interrupt-pending input is 0 and the power-check input is 1.
- R12: A cycle without a write leaves the register unchanged and drives flush, swap and halt to 0 in the following cycle, whatever the write-data input holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | XLEN | Value software writes |
| wr_mask | input | XLEN | Writable-bit mask of this implementation |
| hv_write_ok | input | 1 | Write is permitted to alter the hypervisor bit |
| irq_pending | input | 1 | Some interrupt is pending |
| pow_check_ok | input | 1 | Power-save entry check result |
| cfg_embedded | input | 1 | Embedded MMU variant selected |
| cfg_server64 | input | 1 | 64-bit server variant selected |
| cfg_tgpr_en | input | 1 | Temporary register bank present |
| ext_hflags | input | XLEN | Flags merged into the hidden-flags output |
| msr_q | output | XLEN | Stored machine state register |
| immu_idx | output | 3 | Instruction-side MMU mode index |
| dmmu_idx | output | 3 | Data-side MMU mode index |
| hflags | output | XLEN | Hidden-flags vector |
| flush_req | output | 1 | One-cycle translation flush request |
| swap_req | output | 1 | One-cycle register-bank swap request |
| excp_prefix | output | XLEN | Exception vector prefix |
| halt_req | output | 1 | One-cycle halt request |

## Verification
The flush and swap requests can fall in the same cycle when one write toggles a translation bit and the temporary-bank bit together, and the halt request can join them when the same write sets the power-save bit. The table drives such combined writes on purpose, including one that also drops privilege on a server configuration so that forced translation bits and the flush decision meet, and each request is compared separately against a model that evaluates every rule from the pre-write register. Random writes with random straps and masks then repeat these collisions many times, and every write is followed by an idle cycle that checks all requests have returned low.

// File: rtl/msr_pkg.sv
package msr_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_PULSE = 1'b1
    } wr_state_e;

    typedef struct packed {
        logic flush;
        logic swap;
        logic halt;
    } side_fx_t;

    localparam logic [31:0] HIGH_PREFIX = 32'hFFF0_0000;

endpackage

// File: rtl/msr_write_filter.sv
module msr_write_filter #(
    parameter int XLEN = 64,
    parameter int B_HV = 60,
    parameter int B_PR = 14,
    parameter int B_EE = 15,
    parameter int B_IR = 5,
    parameter int B_DR = 4
) (
    input  logic [XLEN-1:0] cur_msr,
    input  logic [XLEN-1:0] wr_data,
    input  logic [XLEN-1:0] wr_mask,
    input  logic            hv_write_ok,
    input  logic            server64,
    output logic [XLEN-1:0] staged,
    output logic [XLEN-1:0] final_val
);

    logic hv_free;

    always_comb begin
        hv_free = hv_write_ok && cur_msr[B_HV];
        staged  = wr_data & wr_mask;
        if (!hv_free) begin
            staged[B_HV] = cur_msr[B_HV];
        end
        final_val = staged;
        if (server64 && staged[B_PR]) begin
            final_val[B_EE] = 1'b1;
            final_val[B_IR] = 1'b1;
            final_val[B_DR] = 1'b1;
        end
    end

endmodule

// File: rtl/msr_toggle_detect.sv
module msr_toggle_detect
    import msr_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int B_IR   = 5,
    parameter int B_DR   = 4,
    parameter int B_GS   = 28,
    parameter int B_TGPR = 17,
    parameter int B_EP   = 6,
    parameter int B_POW  = 18
) (
    input  logic [XLEN-1:0] cur_msr,
    input  logic [XLEN-1:0] staged,
    input  logic            embedded,
    input  logic            tgpr_en,
    input  logic            irq_pending,
    input  logic            pow_check_ok,
    output side_fx_t        fx,
    output logic            ep_change,
    output logic            ep_new
);

    logic [XLEN-1:0] diff;

    always_comb begin
        diff      = staged ^ cur_msr;
        fx.flush  = diff[B_IR] || diff[B_DR] || (embedded && diff[B_GS]);
        fx.swap   = tgpr_en && diff[B_TGPR];
        fx.halt   = staged[B_POW] && !irq_pending && pow_check_ok;
        ep_change = diff[B_EP];
        ep_new    = staged[B_EP];
    end

endmodule

// File: rtl/msr_mode_index.sv
module msr_mode_index #(
    parameter int XLEN = 64,
    parameter int B_PR = 14,
    parameter int B_IR = 5,
    parameter int B_DR = 4,
    parameter int B_IS = 2,
    parameter int B_DS = 3,
    parameter int B_HV = 60,
    parameter int B_GS = 28
) (
    input  logic [XLEN-1:0] msr,
    input  logic            embedded,
    output logic [2:0]      immu_idx,
    output logic [2:0]      dmmu_idx
);

    logic [2:0] side_idx [2];

    for (genvar g = 0; g < 2; g++) begin : g_side
        localparam int TRANS_BIT = (g == 0) ? B_IR : B_DR;
        localparam int SPACE_BIT = (g == 0) ? B_IS : B_DS;
        always_comb begin
            side_idx[g][0] = !msr[B_PR];
            if (embedded) begin
                side_idx[g][1] = msr[SPACE_BIT];
                side_idx[g][2] = msr[B_GS];
            end else begin
                side_idx[g][1] = !msr[TRANS_BIT];
                side_idx[g][2] = msr[B_HV];
            end
        end
    end

    assign immu_idx = side_idx[0];
    assign dmmu_idx = side_idx[1];

endmodule

// File: rtl/msr_write_ctrl.sv
module msr_write_ctrl
    import msr_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int B_LE   = 0,
    parameter int B_SA   = 1,
    parameter int B_IS   = 2,
    parameter int B_DS   = 3,
    parameter int B_DR   = 4,
    parameter int B_IR   = 5,
    parameter int B_EP   = 6,
    parameter int B_AP   = 7,
    parameter int B_BE   = 9,
    parameter int B_SE   = 10,
    parameter int B_FP   = 13,
    parameter int B_PR   = 14,
    parameter int B_EE   = 15,
    parameter int B_TGPR = 17,
    parameter int B_POW  = 18,
    parameter int B_VSX  = 23,
    parameter int B_VR   = 25,
    parameter int B_GS   = 28,
    parameter int B_CM   = 31,
    parameter int B_HV   = 60,
    parameter int B_SF   = 63,
    parameter logic [XLEN-1:0] RST_MSR = XLEN'(1) << B_HV
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    input  logic [XLEN-1:0] wr_mask,
    input  logic            hv_write_ok,
    input  logic            irq_pending,
    input  logic            pow_check_ok,
    input  logic            cfg_embedded,
    input  logic            cfg_server64,
    input  logic            cfg_tgpr_en,
    input  logic [XLEN-1:0] ext_hflags,
    output logic [XLEN-1:0] msr_q,
    output logic [2:0]      immu_idx,
    output logic [2:0]      dmmu_idx,
    output logic [XLEN-1:0] hflags,
    output logic            flush_req,
    output logic            swap_req,
    output logic [XLEN-1:0] excp_prefix,
    output logic            halt_req
);

    localparam logic [XLEN-1:0] ONE = XLEN'(1);
    localparam logic [XLEN-1:0] HF_MASK =
        (ONE << B_VR) | (ONE << B_AP) | (ONE << B_SA) | (ONE << B_PR) |
        (ONE << B_FP) | (ONE << B_SE) | (ONE << B_BE) | (ONE << B_LE) |
        (ONE << B_VSX) | (ONE << B_IR) | (ONE << B_DR) | (ONE << B_CM) |
        (ONE << B_SF) | (ONE << B_HV);
    localparam logic [XLEN-1:0] PREFIX_ON = XLEN'(HIGH_PREFIX);

    logic [XLEN-1:0] staged;
    logic [XLEN-1:0] final_val;
    side_fx_t        fx_d;
    side_fx_t        fx_q;
    logic            ep_change;
    logic            ep_new;
    wr_state_e       state_q;
    wr_state_e       state_d;

    msr_write_filter #(
        .XLEN(XLEN), .B_HV(B_HV), .B_PR(B_PR), .B_EE(B_EE),
        .B_IR(B_IR), .B_DR(B_DR)
    ) u_filter (
        .cur_msr    (msr_q),
        .wr_data    (wr_data),
        .wr_mask    (wr_mask),
        .hv_write_ok(hv_write_ok),
        .server64   (cfg_server64),
        .staged     (staged),
        .final_val  (final_val)
    );

    msr_toggle_detect #(
        .XLEN(XLEN), .B_IR(B_IR), .B_DR(B_DR), .B_GS(B_GS),
        .B_TGPR(B_TGPR), .B_EP(B_EP), .B_POW(B_POW)
    ) u_toggle (
        .cur_msr     (msr_q),
        .staged      (staged),
        .embedded    (cfg_embedded),
        .tgpr_en     (cfg_tgpr_en),
        .irq_pending (irq_pending),
        .pow_check_ok(pow_check_ok),
        .fx          (fx_d),
        .ep_change   (ep_change),
        .ep_new      (ep_new)
    );

    msr_mode_index #(
        .XLEN(XLEN), .B_PR(B_PR), .B_IR(B_IR), .B_DR(B_DR),
        .B_IS(B_IS), .B_DS(B_DS), .B_HV(B_HV), .B_GS(B_GS)
    ) u_index (
        .msr     (msr_q),
        .embedded(cfg_embedded),
        .immu_idx(immu_idx),
        .dmmu_idx(dmmu_idx)
    );

    // Register and prefix update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msr_q       <= RST_MSR;
            excp_prefix <= '0;
            fx_q        <= '0;
        end else if (wr_en) begin
            msr_q <= final_val;
            fx_q  <= fx_d;
            if (ep_change) begin
                excp_prefix <= ep_new ? PREFIX_ON : '0;
            end
        end
    end

    // Request sequencer: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request sequencer: transitions LOAD, REPEAT, RETIRE
    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = wr_en ? ST_PULSE : ST_IDLE;
            ST_PULSE: state_d = wr_en ? ST_PULSE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Request sequencer: outputs
    always_comb begin
        unique case (state_q)
            ST_PULSE: begin
                flush_req = fx_q.flush;
                swap_req  = fx_q.swap;
                halt_req  = fx_q.halt;
            end
            default: begin
                flush_req = 1'b0;
                swap_req  = 1'b0;
                halt_req  = 1'b0;
            end
        endcase
    end

    assign hflags = (msr_q & HF_MASK) | ext_hflags;

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (!flush_req && !swap_req && !halt_req));

    p_hold_value_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(msr_q));

    p_hv_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(hv_write_ok && msr_q[B_HV])) |=> (msr_q[B_HV] == $past(msr_q[B_HV])));

    p_pr_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cfg_server64 && wr_data[B_PR] && wr_mask[B_PR])
        |=> (msr_q[B_EE] && msr_q[B_IR] && msr_q[B_DR]));

    p_flush_ir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((wr_data[B_IR] && wr_mask[B_IR]) != msr_q[B_IR])) |=> flush_req);

    p_prefix_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
        excp_prefix == (msr_q[B_EP] ? PREFIX_ON : '0));

endmodule

// File: tb/sim_msr_write_ctrl.sv
module sim_msr_write_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int P_LE = 0, P_SA = 1, P_IS = 2, P_DS = 3, P_DR = 4, P_IR = 5;
    localparam int P_EP = 6, P_AP = 7, P_BE = 9, P_SE = 10, P_FP = 13, P_PR = 14;
    localparam int P_EE = 15, P_TGPR = 17, P_POW = 18, P_VSX = 23, P_VR = 25;
    localparam int P_GS = 28, P_CM = 31, P_HV = 60, P_SF = 63;
    localparam logic [63:0] ONES = '1;
    localparam logic [63:0] HFM =
        (64'd1 << P_VR) | (64'd1 << P_AP) | (64'd1 << P_SA) | (64'd1 << P_PR) |
        (64'd1 << P_FP) | (64'd1 << P_SE) | (64'd1 << P_BE) | (64'd1 << P_LE) |
        (64'd1 << P_VSX) | (64'd1 << P_IR) | (64'd1 << P_DR) | (64'd1 << P_CM) |
        (64'd1 << P_SF) | (64'd1 << P_HV);

    typedef struct packed {
        logic [63:0] data;
        logic [63:0] mask;
        logic        hvok;
        logic        emb;
        logic        srv;
        logic        tg;
        logic        irq;
        logic        pok;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{64'h0000_0000_0002_0020, ONES, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        '{64'h0000_0000_0006_4040, ONES, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        '{64'h0000_0000_1000_000C, ONES, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{ONES, 64'h0000_0000_FFFF_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{64'h0000_0000_0000_0000, ONES, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{64'h1000_0000_0000_0000, ONES, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{64'h0000_0000_0004_0000, ONES, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
        '{64'h8000_0000_8202_4821, ONES, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] wr_mask = '0;
    logic        hv_write_ok = 1'b0;
    logic        irq_pending = 1'b0;
    logic        pow_check_ok = 1'b0;
    logic        cfg_embedded = 1'b0;
    logic        cfg_server64 = 1'b0;
    logic        cfg_tgpr_en = 1'b0;
    logic [63:0] ext_hflags = '0;
    logic [63:0] msr_q;
    logic [2:0]  immu_idx;
    logic [2:0]  dmmu_idx;
    logic [63:0] hflags;
    logic        flush_req;
    logic        swap_req;
    logic [63:0] excp_prefix;
    logic        halt_req;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic [63:0] ref_msr;
    logic [63:0] ref_pfx;

    always #(CLK_PERIOD/2) clk = ~clk;

    msr_write_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_mask(wr_mask), .hv_write_ok(hv_write_ok), .irq_pending(irq_pending),
        .pow_check_ok(pow_check_ok), .cfg_embedded(cfg_embedded),
        .cfg_server64(cfg_server64), .cfg_tgpr_en(cfg_tgpr_en),
        .ext_hflags(ext_hflags), .msr_q(msr_q), .immu_idx(immu_idx),
        .dmmu_idx(dmmu_idx), .hflags(hflags), .flush_req(flush_req),
        .swap_req(swap_req), .excp_prefix(excp_prefix), .halt_req(halt_req)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] model_idx(input logic [63:0] m, input logic emb, input bit data_side);
        logic [2:0] r;
        r[0] = ~m[P_PR];
        if (emb) begin
            r[1] = data_side ? m[P_DS] : m[P_IS];
            r[2] = m[P_GS];
        end else begin
            r[1] = data_side ? ~m[P_DR] : ~m[P_IR];
            r[2] = m[P_HV];
        end
        return r;
    endfunction

    task automatic check_static(input string tag);
        chk({tag, " R8/R9 instr index"}, 64'(immu_idx), 64'(model_idx(ref_msr, cfg_embedded, 1'b0)));
        chk({tag, " R8/R9 data index"}, 64'(dmmu_idx), 64'(model_idx(ref_msr, cfg_embedded, 1'b1)));
        chk({tag, " R10 hidden flags"}, hflags, (ref_msr & HFM) | ext_hflags);
        chk({tag, " R6 prefix"}, excp_prefix, ref_pfx);
    endtask

    task automatic do_write(input vec_t v, input logic [63:0] xf);
        logic [63:0] s;
        logic [63:0] f;
        logic e_fl, e_sw, e_ht;
        @(negedge clk);
        wr_data = v.data; wr_mask = v.mask; hv_write_ok = v.hvok;
        cfg_embedded = v.emb; cfg_server64 = v.srv; cfg_tgpr_en = v.tg;
        irq_pending = v.irq; pow_check_ok = v.pok; ext_hflags = xf;
        wr_en = 1'b1;
        s = v.data & v.mask;
        if (!(v.hvok && ref_msr[P_HV])) s[P_HV] = ref_msr[P_HV];
        e_fl = (s[P_IR] ^ ref_msr[P_IR]) | (s[P_DR] ^ ref_msr[P_DR]) |
               (v.emb & (s[P_GS] ^ ref_msr[P_GS]));
        e_sw = v.tg & (s[P_TGPR] ^ ref_msr[P_TGPR]);
        e_ht = s[P_POW] & ~v.irq & v.pok;
        if (s[P_EP] != ref_msr[P_EP]) ref_pfx = s[P_EP] ? 64'hFFF0_0000 : 64'h0;
        f = s;
        if (v.srv && s[P_PR]) begin
            f[P_EE] = 1'b1; f[P_IR] = 1'b1; f[P_DR] = 1'b1;
        end
        ref_msr = f;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = {$urandom, $urandom};
        chk("R2 stored value", msr_q, ref_msr);
        chk("R3 hv bit", 64'(msr_q[P_HV]), 64'(ref_msr[P_HV]));
        if (v.srv && s[P_PR])
            chk("R7 forced EE/IR/DR", 64'({msr_q[P_EE], msr_q[P_IR], msr_q[P_DR]}), 64'h7);
        chk("R4 flush request", 64'(flush_req), 64'(e_fl));
        chk("R5 swap request", 64'(swap_req), 64'(e_sw));
        chk("R11 halt request", 64'(halt_req), 64'(e_ht));
        check_static("write");
        @(negedge clk);
        chk("R12 requests low after idle", 64'({flush_req, swap_req, halt_req}), 64'h0);
        chk("R12 value held while idle", msr_q, ref_msr);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        ref_msr = 64'd1 << P_HV;
        ref_pfx = '0;
        wr_data = ONES;
        wr_mask = ONES;
        repeat (3) @(negedge clk);
        // R1: values while reset is held
        chk("R1 reset value", msr_q, 64'd1 << P_HV);
        chk("R1 reset requests", 64'({flush_req, swap_req, halt_req}), 64'h0);
        chk("R1 reset prefix", excp_prefix, 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 after release", msr_q, 64'd1 << P_HV);
        chk("R12 no write, data ignored", 64'({flush_req, swap_req, halt_req}), 64'h0);
        check_static("reset");

        // Table walk: combined side effects in one write
        for (int i = 0; i < NVEC; i++) begin
            do_write(VECS[i], 64'(i) << 40);
        end

        // Random writes with random straps
        for (int k = 0; k < 400; k++) begin
            vec_t rv;
            rv.data = {$urandom, $urandom};
            rv.mask = ($urandom % 3 == 0) ? {$urandom, $urandom} : ONES;
            rv.hvok = 1'($urandom);
            rv.emb  = 1'($urandom);
            rv.srv  = 1'($urandom);
            rv.tg   = 1'($urandom);
            rv.irq  = 1'($urandom);
            rv.pok  = 1'($urandom);
            do_write(rv, ($urandom % 2 == 0) ? 64'h0 : {$urandom, $urandom});
        end

        // Back-to-back writes: requests from the second write show next cycle
        @(negedge clk);
        wr_mask = ONES; hv_write_ok = 1'b0; cfg_embedded = 1'b0; cfg_server64 = 1'b0;
        cfg_tgpr_en = 1'b1; irq_pending = 1'b0; pow_check_ok = 1'b1; ext_hflags = '0;
        wr_data = ref_msr ^ (64'd1 << P_IR);
        wr_data[P_POW] = 1'b0;
        wr_en = 1'b1;
        @(negedge clk);
        chk("R4 first of pair", 64'(flush_req), 64'h1);
        wr_data = msr_q ^ (64'd1 << P_TGPR);
        wr_data[P_IR] = msr_q[P_IR];
        wr_data[P_DR] = msr_q[P_DR];
        wr_data[P_POW] = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R4 second of pair no flush", 64'(flush_req), 64'h0);
        chk("R5 second of pair swap", 64'(swap_req), 64'h1);
        @(negedge clk);
        chk("R12 pair retired", 64'({flush_req, swap_req, halt_req}), 64'h0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule